// File: doc/BRIEF.md
# Synthetic Mesh Traffic Destination Generator

This block sits beside one node of a three-dimensional mesh that is under test. It knows the node's own coordinates and, once per clock, decides whether to inject a packet. It then works out where that packet goes. The destination comes either from a fixed permutation of the source coordinates or from a uniform random draw over all nodes. Every packet it issues has the same length in flits.

Injection is paced by comparing a pseudo-random sample against a programmable threshold. The permutations come in two variants:

- The symmetric variant works on coordinate values.
- The asymmetric variant works on bit fields of the concatenated coordinate word `{x, y, z}`. It rotates or swaps that word and then cuts it back into fields of the native widths.

A destination that falls outside a dimension's radix is never issued. In random mode it is redrawn on a later cycle. In a fixed pattern the attempt is flagged and dropped. A destination equal to the node itself is either dropped or issued, as set by a configuration pin.

The output is a valid/ready stream. Once `pkt_valid` is high, the destination and flit count hold until `pkt_ready` is sampled high on a rising edge. A new attempt is made only in a cycle where the output slot is empty or is being emptied. While the stream is stalled, no draw is used for injection.

Top module: `mesh_dest_gen`

## Requirements
- R1: After reset, `pkt_valid` and `bad_dst` are 0.
- R2: With `pat_sel`=0 (transpose) and `asym_en`=0, the destination is (y, z, x). If any of those values is not below its dimension's radix, the destination is invalid.
- R3: With `pat_sel`=1 (complement), in either variant, the destination is (KX-1-x, KY-1-y, KZ-1-z).
- R4: With `pat_sel`=2 (worst case) and `asym_en`=0, the destination is (KX-1-z, KY-1-y, KZ-1-x). Any field that is negative or not below its radix makes the destination invalid.
- R5: With `pat_sel`=0 and `asym_en`=1, the word {x,y,z} is rotated left by BX bits, where BX is the width of x. The result is then read back as {x',y',z'} using the widths BX, BY and BZ. A field not below its radix makes the destination invalid.
- R6: With `pat_sel`=2 and `asym_en`=1, the top BX bits and the bottom BX bits of {x,y,z} are exchanged. The word is read back as fields, and every field is then bitwise inverted. A field not below its radix makes the destination invalid.
- R7: With `pat_sel`=3 (random), every issued destination lies inside the mesh. Out-of-range draws are discarded and redrawn on a later cycle, and `bad_dst` is not raised.
- R8: `pkt_flits` equals FLITS (default 5) on every issued packet.
- R9: An attempt injects when the sample is below `rate_thr`. A threshold of 0 never injects. A threshold of 2^RW injects on every attempt.
- R10: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` stays 1 and the destination does not change.
- R11: An injecting attempt with an invalid fixed-pattern destination issues no packet. It raises `bad_dst` for the following cycle.
- R12: A destination equal to the node's own coordinates is issued when `self_send` is 1 and dropped when `self_send` is 0. A dropped self-destination does not raise `bad_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | BX | This node's x coordinate |
| node_y | input | BY | This node's y coordinate |
| node_z | input | BZ | This node's z coordinate |
| pat_sel | input | 2 | Pattern: 0 transpose, 1 complement, 2 worst case, 3 random |
| asym_en | input | 1 | Selects the bit-field (asymmetric) variant |
| self_send | input | 1 | 1 issues self-addressed packets, 0 drops them |
| rate_thr | input | RW+1 | Injection threshold |
| pkt_valid | output | 1 | Packet request pending |
| pkt_ready | input | 1 | Consumer accepts the pending packet |
| pkt_dst_x | output | BX | Destination x |
| pkt_dst_y | output | BY | Destination y |
| pkt_dst_z | output | BZ | Destination z |
| pkt_flits | output | FW | Packet length in flits |
| bad_dst | output | 1 | Pulse: a fixed pattern produced an out-of-mesh destination |

## Verification
The bench runs with a non-power-of-two x radix, so that both permutation variants can produce out-of-mesh values.

- Getting the range check wrong would either issue those values or flag valid ones.
- Rotating or swapping in the wrong direction gives destinations that differ from the hand-computed vectors, for example (2,2,1) for the asymmetric transpose of (5,1,0).
- A fixed point of the asymmetric worst case, and one of the transpose, probe the self-destination rule. An inverted `self_send` would leak or lose those packets.

Random mode is run long enough to catch an unredrawn out-of-range x. Back-pressure is checked by changing the source coordinates while the output is stalled; a design that refreshes a held packet would show the new destination early.

// File: rtl/mesh_dest_pkg.sv
package mesh_dest_pkg;
  localparam int LFSR_W = 32;
  localparam int DEF_FLITS = 5;

  typedef enum logic [1:0] {
    PAT_TRANSPOSE  = 2'd0,
    PAT_COMPLEMENT = 2'd1,
    PAT_WORST      = 2'd2,
    PAT_RANDOM     = 2'd3
  } pattern_e;
endpackage

// File: rtl/mesh_lfsr.sv
module mesh_lfsr #(
  parameter logic [31:0] SEED = 32'h1D87_2A5B
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] state
);
  logic fb;

  // taps 32,22,2,1: maximal length sequence
  assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[30:0], fb};
  end

  // the all-zero state would lock the generator and freeze both injection and draws
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) state != '0)
    else $error("lfsr reached zero");
endmodule

// File: rtl/mesh_dest_map.sv
module mesh_dest_map
  import mesh_dest_pkg::*;
#(
  parameter int KX = 8,
  parameter int KY = 8,
  parameter int KZ = 8,
  localparam int BX = $clog2(KX),
  localparam int BY = $clog2(KY),
  localparam int BZ = $clog2(KZ),
  localparam int BW = BX + BY + BZ
) (
  input  logic [BX-1:0] src_x,
  input  logic [BY-1:0] src_y,
  input  logic [BZ-1:0] src_z,
  input  pattern_e      pat,
  input  logic          asym,
  input  logic [BW-1:0] rnd,
  output logic [BX-1:0] dst_x,
  output logic [BY-1:0] dst_y,
  output logic [BZ-1:0] dst_z,
  output logic          invalid
);
  logic [BW-1:0] word, rot_w, swp_w, sel_w;
  int tx, ty, tz;
  logic use_word;

  assign word  = {src_x, src_y, src_z};
  assign rot_w = {word[BW-BX-1:0], word[BW-1:BW-BX]};

  generate
    if (BW == 2 * BX) begin : g_swap_edge
      assign swp_w = ~{word[BX-1:0], word[BW-1:BW-BX]};
    end else begin : g_swap_mid
      assign swp_w = ~{word[BX-1:0], word[BW-BX-1:BX], word[BW-1:BW-BX]};
    end
  endgenerate

  always_comb begin
    tx = 0; ty = 0; tz = 0;
    use_word = 1'b0;
    sel_w = rnd;
    unique case (pat)
      PAT_TRANSPOSE: begin
        if (asym) begin use_word = 1'b1; sel_w = rot_w; end
        else begin tx = int'(src_y); ty = int'(src_z); tz = int'(src_x); end
      end
      PAT_COMPLEMENT: begin
        tx = KX - 1 - int'(src_x);
        ty = KY - 1 - int'(src_y);
        tz = KZ - 1 - int'(src_z);
      end
      PAT_WORST: begin
        if (asym) begin use_word = 1'b1; sel_w = swp_w; end
        else begin
          tx = KX - 1 - int'(src_z);
          ty = KY - 1 - int'(src_y);
          tz = KZ - 1 - int'(src_x);
        end
      end
      default: begin use_word = 1'b1; sel_w = rnd; end
    endcase
    if (use_word) begin
      tx = int'(sel_w[BW-1:BY+BZ]);
      ty = int'(sel_w[BY+BZ-1:BZ]);
      tz = int'(sel_w[BZ-1:0]);
    end
    invalid = (tx < 0) || (tx >= KX) || (ty < 0) || (ty >= KY) ||
              (tz < 0) || (tz >= KZ);
    dst_x = BX'(tx);
    dst_y = BY'(ty);
    dst_z = BZ'(tz);
  end
endmodule

// File: rtl/mesh_dest_gen.sv
module mesh_dest_gen
  import mesh_dest_pkg::*;
#(
  parameter int KX = 8,
  parameter int KY = 8,
  parameter int KZ = 8,
  parameter int RW = 8,
  parameter int FLITS = DEF_FLITS,
  parameter logic [31:0] SEED = 32'h1D87_2A5B,
  localparam int BX = $clog2(KX),
  localparam int BY = $clog2(KY),
  localparam int BZ = $clog2(KZ),
  localparam int BW = BX + BY + BZ,
  localparam int FW = $clog2(FLITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BX-1:0] node_x,
  input  logic [BY-1:0] node_y,
  input  logic [BZ-1:0] node_z,
  input  logic [1:0]    pat_sel,
  input  logic          asym_en,
  input  logic          self_send,
  input  logic [RW:0]   rate_thr,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [BX-1:0] pkt_dst_x,
  output logic [BY-1:0] pkt_dst_y,
  output logic [BZ-1:0] pkt_dst_z,
  output logic [FW-1:0] pkt_flits,
  output logic          bad_dst
);
  logic [31:0]   lfsr;
  logic [BX-1:0] m_x;
  logic [BY-1:0] m_y;
  logic [BZ-1:0] m_z;
  logic          m_inv;
  pattern_e      pat;
  logic          attempt, hit, is_self, load, fixed_pat;
  logic          pend_q, bad_q;
  logic [BX-1:0] dx_q;
  logic [BY-1:0] dy_q;
  logic [BZ-1:0] dz_q;

  initial begin
    if (RW + BW > LFSR_W) $error("rate and coordinate draws exceed lfsr width");
    if (2 * BX > BW) $error("x field wider than half the coordinate word");
  end

  assign pat = pattern_e'(pat_sel);

  mesh_lfsr #(.SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .state(lfsr)
  );

  mesh_dest_map #(.KX(KX), .KY(KY), .KZ(KZ)) u_map (
    .src_x  (node_x),
    .src_y  (node_y),
    .src_z  (node_z),
    .pat    (pat),
    .asym   (asym_en),
    .rnd    (lfsr[LFSR_W-1 -: BW]),
    .dst_x  (m_x),
    .dst_y  (m_y),
    .dst_z  (m_z),
    .invalid(m_inv)
  );

  assign attempt   = !pend_q || pkt_ready;
  assign hit       = {1'b0, lfsr[RW-1:0]} < rate_thr;
  assign is_self   = (m_x == node_x) && (m_y == node_y) && (m_z == node_z);
  assign fixed_pat = (pat != PAT_RANDOM);
  assign load      = attempt && hit && !m_inv && (self_send || !is_self);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      bad_q  <= 1'b0;
      dx_q   <= '0;
      dy_q   <= '0;
      dz_q   <= '0;
    end else begin
      bad_q <= attempt && hit && m_inv && fixed_pat;
      if (load) begin
        pend_q <= 1'b1;
        dx_q   <= m_x;
        dy_q   <= m_y;
        dz_q   <= m_z;
      end else if (attempt) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pkt_valid = pend_q;
  assign pkt_dst_x = dx_q;
  assign pkt_dst_y = dy_q;
  assign pkt_dst_z = dz_q;
  assign pkt_flits = FW'(FLITS);
  assign bad_dst   = bad_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_dst_x) &&
                                   $stable(pkt_dst_y) && $stable(pkt_dst_z)))
    else $error("held packet changed");

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (int'(pkt_dst_x) < KX && int'(pkt_dst_y) < KY && int'(pkt_dst_z) < KZ))
    else $error("destination outside mesh");

  p_zero_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_thr == '0) |=> !$rose(pkt_valid))
    else $error("injection with zero threshold");

  p_bad_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_dst |-> !$rose(pkt_valid))
    else $error("flagged attempt produced a packet");

  p_self_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pkt_valid) && !$past(self_send)) |->
      !(pkt_dst_x == $past(node_x) && pkt_dst_y == $past(node_y) &&
        pkt_dst_z == $past(node_z)))
    else $error("self packet issued while dropping");
endmodule

// File: tb/mesh_dest_gen_tb.sv
module mesh_dest_gen_tb_top;
  localparam int KX = 6, KY = 4, KZ = 2, RW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] node_x = '0;
  logic [1:0] node_y = '0;
  logic [0:0] node_z = '0;
  logic [1:0] pat_sel = '0;
  logic       asym_en = 1'b0;
  logic       self_send = 1'b1;
  logic [RW:0] rate_thr = '0;
  logic       pkt_ready = 1'b1;
  logic       pkt_valid, bad_dst;
  logic [2:0] pkt_dst_x;
  logic [1:0] pkt_dst_y;
  logic [0:0] pkt_dst_z;
  logic [2:0] pkt_flits;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mesh_dest_gen #(.KX(KX), .KY(KY), .KZ(KZ), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .node_x(node_x), .node_y(node_y), .node_z(node_z),
    .pat_sel(pat_sel), .asym_en(asym_en), .self_send(self_send),
    .rate_thr(rate_thr), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_dst_x(pkt_dst_x), .pkt_dst_y(pkt_dst_y), .pkt_dst_z(pkt_dst_z),
    .pkt_flits(pkt_flits), .bad_dst(bad_dst)
  );

  typedef struct packed {
    logic       asym;
    logic [1:0] pat;
    logic [2:0] sx; logic [1:0] sy; logic [0:0] sz;
    logic       ok;
    logic [2:0] ex; logic [1:0] ey; logic [0:0] ez;
  } vec_t;

  localparam int NV = 12;
  // fields: asym, pat, src x,y,z, expect valid, expected x,y,z
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 3'd1, 2'd1, 1'd0, 1'b1, 3'd1, 2'd0, 1'd1},  // R2
    '{1'b0, 2'd0, 3'd5, 2'd1, 1'd0, 1'b0, 3'd0, 2'd0, 1'd0},  // R2 z'=5 out
    '{1'b0, 2'd1, 3'd5, 2'd1, 1'd0, 1'b1, 3'd0, 2'd2, 1'd1},  // R3
    '{1'b0, 2'd1, 3'd0, 2'd3, 1'd1, 1'b1, 3'd5, 2'd0, 1'd0},  // R3
    '{1'b0, 2'd2, 3'd1, 2'd1, 1'd0, 1'b1, 3'd5, 2'd2, 1'd0},  // R4
    '{1'b0, 2'd2, 3'd5, 2'd1, 1'd0, 1'b0, 3'd0, 2'd0, 1'd0},  // R4 negative z'
    '{1'b1, 2'd0, 3'd5, 2'd1, 1'd0, 1'b1, 3'd2, 2'd2, 1'd1},  // R5
    '{1'b1, 2'd0, 3'd0, 2'd3, 1'd1, 1'b0, 3'd0, 2'd0, 1'd0},  // R5 x'=7 out
    '{1'b1, 2'd2, 3'd5, 2'd1, 1'd0, 1'b1, 3'd5, 2'd1, 1'd0},  // R6 fixed point
    '{1'b1, 2'd2, 3'd0, 2'd0, 1'd0, 1'b0, 3'd0, 2'd0, 1'd0},  // R6 x'=7 out
    '{1'b1, 2'd2, 3'd3, 2'd2, 1'd1, 1'b1, 3'd2, 2'd2, 1'd0},  // R6
    '{1'b1, 2'd1, 3'd2, 2'd2, 1'd1, 1'b1, 3'd3, 2'd1, 1'd0}   // R3 asym variant
  };

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int x, input int y, input int z);
    node_x = 3'(x); node_y = 2'(y); node_z = 1'(z);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt, bad_seen, out_seen;
    cyc(3);
    // R1 reset state
    check(pkt_valid == 1'b0, "R1 valid", int'(pkt_valid), 0);
    check(bad_dst == 1'b0, "R1 bad_dst", int'(bad_dst), 0);
    rst_n = 1'b1;
    rate_thr = 9'd256;
    pkt_ready = 1'b1;
    self_send = 1'b1;

    for (int i = 0; i < NV; i++) begin
      asym_en = VEC[i].asym;
      pat_sel = VEC[i].pat;
      node_x = VEC[i].sx; node_y = VEC[i].sy; node_z = VEC[i].sz;
      cyc(3);
      if (VEC[i].ok) begin
        check(pkt_valid, $sformatf("R2-6 vec%0d valid", i), int'(pkt_valid), 1);
        check({pkt_dst_x, pkt_dst_y, pkt_dst_z} == {VEC[i].ex, VEC[i].ey, VEC[i].ez},
              $sformatf("R2-6 vec%0d dst", i),
              int'({pkt_dst_x, pkt_dst_y, pkt_dst_z}), int'({VEC[i].ex, VEC[i].ey, VEC[i].ez}));
        check(pkt_flits == 3'd5, "R8 flits", int'(pkt_flits), 5);
      end else begin
        // R11 invalid fixed destination: flagged, no packet
        check(!pkt_valid, $sformatf("R11 vec%0d no packet", i), int'(pkt_valid), 0);
        check(bad_dst, $sformatf("R11 vec%0d flag", i), int'(bad_dst), 1);
      end
    end

    // R12 self destination, transpose of (1,1,1)
    asym_en = 1'b0; pat_sel = 2'd0; set_src(1, 1, 1);
    self_send = 1'b0;
    cyc(3);
    check(!pkt_valid, "R12 dropped self", int'(pkt_valid), 0);
    check(!bad_dst, "R12 no flag", int'(bad_dst), 0);
    self_send = 1'b1;
    cyc(3);
    check(pkt_valid && pkt_dst_x == 3'd1 && pkt_dst_y == 2'd1 && pkt_dst_z == 1'd1,
          "R12 issued self", int'({pkt_dst_x, pkt_dst_y, pkt_dst_z}), int'(6'b001011));

    // R10 hold under back-pressure: complement of (5,1,0) is (0,2,1)
    pat_sel = 2'd1; set_src(5, 1, 0);
    cyc(3);
    pkt_ready = 1'b0;
    cyc(1);
    set_src(0, 3, 1);  // complement would be (5,0,0)
    cyc(4);
    check(pkt_valid && {pkt_dst_x, pkt_dst_y, pkt_dst_z} == {3'd0, 2'd2, 1'd1},
          "R10 held dst", int'({pkt_dst_x, pkt_dst_y, pkt_dst_z}), int'({3'd0, 2'd2, 1'd1}));
    pkt_ready = 1'b1;
    cyc(1);
    check(pkt_valid && {pkt_dst_x, pkt_dst_y, pkt_dst_z} == {3'd5, 2'd0, 1'd0},
          "R10 next dst", int'({pkt_dst_x, pkt_dst_y, pkt_dst_z}), int'({3'd5, 2'd0, 1'd0}));

    // R9 zero threshold never injects
    rate_thr = '0;
    cyc(2);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); if (pkt_valid) cnt++; end
    check(cnt == 0, "R9 zero rate", cnt, 0);
    // R9 full threshold: valid every cycle
    rate_thr = 9'd256;
    cyc(2);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); if (pkt_valid) cnt++; end
    check(cnt == 200, "R9 full rate", cnt, 200);
    // R9 half threshold: roughly half the cycles
    rate_thr = 9'd128;
    cyc(2);
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin cyc(1); if (pkt_valid) cnt++; end
    check(cnt > 350 && cnt < 650, "R9 half rate", cnt, 500);

    // R7 random destinations with redraw, self dropped
    rate_thr = 9'd256; pat_sel = 2'd3; self_send = 1'b0; set_src(2, 1, 0);
    cyc(2);
    cnt = 0; bad_seen = 0; out_seen = 0;
    for (int i = 0; i < 2000; i++) begin
      cyc(1);
      if (bad_dst) bad_seen++;
      if (pkt_valid) begin
        cnt++;
        if (int'(pkt_dst_x) >= KX) out_seen++;
        if (pkt_dst_x == 3'd2 && pkt_dst_y == 2'd1 && pkt_dst_z == 1'd0) out_seen++;
      end
    end
    check(out_seen == 0, "R7 in range and R12 no self", out_seen, 0);
    check(bad_seen == 0, "R7 no flag on redraw", bad_seen, 0);
    check(cnt > 1000 && cnt < 2000, "R7 redraw rate", cnt, 1500);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule